// File: doc/BRIEF.md
# Dual-Base Periodic Timer

This block generates periodic events on four independent channels. The events are derived from the bus clock through two counting stages. The first stage has two 8-bit prescalers, called micro bases. Each micro base counts down from its own start value and gives a one-cycle tick when it wraps. The second stage has four 16-bit channel counters. Every channel counts ticks from one of the two micro bases, chosen by a per-channel select bit. The product of the two stages gives each channel a 24-bit period.

Software programs the block through a simple synchronous register port. Through that port it sets the start values, base selects, the module and channel enables, and the irq enables. It can also strobe a reload of any counter, clear time-out flags, and read any channel's live count in a single 16-bit access.

Each time-out does three things:
- It sets a sticky flag.
- It sends a one-cycle trigger pulse to hardware.
- It raises an interrupt line, if enabled, for as long as the flag stays set.

Top module: `dual_base_period_timer`

## Requirements
- R1: A micro base with start value M gives one tick every M+1 bus clocks, which a channel with load 0 turns into a time-out every M+1 cycles.
- R2: A channel with load C on a base with start value M times out every (M+1)*(C+1) bus clocks; micro start values live at addresses 6 (base 0) and 7 (base 1), channel loads at 8+i.
- R3: Bit i of the select register (address 2) routes channel i to base 0 when 0 and to base 1 when 1; two channels on different bases run at independent periods, and re-routing changes the period.
- R4: A channel counts only while the module enable (address 0 bit 0) and its own enable (address 1 bit i) are both 1; otherwise its count holds and it produces no time-out.
- R5: A channel enabled from the disabled state reloads its count from its load value before it counts, and a base that becomes selected by an enabled channel restarts from its start value.
- R6: Writing 1 to bit i of the force register (address 3) reloads channel i from its load value at that write edge; the count then decrements on the following ticks.
- R7: Writing 1 to bit 8+b of the force register reloads micro base b at the write edge, so its next tick falls M+1 cycles after that edge, whatever its phase was.
- R8: A read with rd_en_i returns the full 16-bit register value (live count of channel i at address 12+i) on rd_data_o in the cycle after the request, as it stood just before the sampling edge.
- R9: A time-out sets bit i of the flag register (address 4); writing 1 to a flag bit clears it, but a time-out at the same edge as the clear leaves the flag set.
- R10: irq_o[i] is 1 exactly while flag i and irq-enable bit i (address 5) are both 1.
- R11: Each time-out gives a one-cycle pulse on trig_o[i] one cycle later, whether the irq enable is set or not.
- R12: After reset every register, count and flag is 0; clearing the module enable clears all flags at once and stops every counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Read data, valid one cycle after the request |
| irq_o | output | 4 | Per-channel interrupt request |
| trig_o | output | 4 | Per-channel one-cycle time-out trigger |

## Verification
Two events can fall in the same cycle: a channel's time-out, which sets its flag, and a software write-one-to-clear of that flag. The bench provokes the clash on a channel with a known period of 8 cycles. It waits for a trigger pulse and then counts seven more cycles, so that the clear write is sampled on exactly the edge of the next time-out. It judges the result twice: it confirms a fresh trigger pulse at that edge, and it reads the flag back as still set. An ordinary clear away from a time-out is read back as zero, for contrast.

// File: rtl/dbpt_pkg.sv
// Package for the dual-base periodic timer.
// Holds the register offsets and layout constants that the register file
// and the top share. Assumes exactly two micro bases.
package dbpt_pkg;
    localparam int NBASE        = 2;
    localparam int REG_CTRL     = 0;
    localparam int REG_CHEN     = 1;
    localparam int REG_SEL      = 2;
    localparam int REG_FORCE    = 3;
    localparam int REG_FLAG     = 4;
    localparam int REG_IRQEN    = 5;
    localparam int REG_MLOAD    = 6;
    localparam int FORCE_MT_LSB = 8;
    localparam int CLOAD_BASE   = REG_MLOAD + NBASE;

    // Number of register slots used for a given channel count
    function automatic int regmap_size(input int nch);
        return CLOAD_BASE + 2 * nch;
    endfunction
endpackage

// File: rtl/dbpt_microbase.sv
// Micro base prescaler: an 8-bit modulus down-counter.
// While active it counts once per clock and ticks for one cycle on zero, then
// reloads, so the tick period is load+1. It restarts from load when it
// becomes active or when forced. Assumes load_val is stable while it runs.
module dbpt_microbase #(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          force_ld,
    input  logic [MW-1:0] load_val,
    output logic          tick
);
    logic [MW-1:0] cnt_q;
    logic          run_q;

    // Tick when running in phase, not being reloaded, and at zero
    assign tick = active & run_q & ~force_ld & (cnt_q == '0);

    // Counter state: restart on activation or force, wrap on zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= active;
            if (!active || !run_q || force_ld) begin
                cnt_q <= load_val;
            end else if (cnt_q == '0) begin
                cnt_q <= load_val;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbpt_channel.sv
// Channel counter: a 16-bit modulus down-counter stepped by base ticks.
// On a tick at zero it reloads and flags a time-out for that cycle. It
// reloads on enable and on force at any time, and holds while disabled.
module dbpt_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          force_ld,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          timeout
);
    logic [CW-1:0] cnt_q;
    logic          en_q;

    assign count = cnt_q;

    // Time-out is a tick on zero in steady running, never during a reload
    assign timeout = en & en_q & ~force_ld & tick & (cnt_q == '0);

    // Counter state: load on enable or force, step on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= en;
            if (force_ld || (en && !en_q)) begin
                cnt_q <= load_val;
            end else if (en && tick) begin
                if (cnt_q == '0) begin
                    cnt_q <= load_val;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dbpt_regs.sv
// Register file of the dual-base periodic timer.
// Holds the enables, selects, load values, flags and irq enables. It decodes
// the force strobes straight from the write port. Reads are registered
// one cycle after the request, as a whole-word capture.
module dbpt_regs
    import dbpt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int MW  = 8,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [CW-1:0]             wr_data,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    output logic [CW-1:0]             rd_data,
    input  logic [NCH-1:0]            timeout,
    input  logic [NCH-1:0][CW-1:0]    cnts,
    output logic                      menable,
    output logic [NCH-1:0]            chen,
    output logic [NCH-1:0]            sel,
    output logic [NCH-1:0]            ch_force,
    output logic [NBASE-1:0]          mt_force,
    output logic [NBASE-1:0][MW-1:0]  mload,
    output logic [NCH-1:0][CW-1:0]    cload,
    output logic [NCH-1:0]            flags,
    output logic [NCH-1:0]            irqen
);
    localparam int CNT_BASE = CLOAD_BASE + NCH;

    logic           wr_ctrl, wr_flag, wr_force, mod_off;
    logic [NCH-1:0] flag_clr;
    logic [CW-1:0]  rd_mux;

    assign wr_ctrl  = wr_en && (wr_addr == AW'(REG_CTRL));
    assign wr_flag  = wr_en && (wr_addr == AW'(REG_FLAG));
    assign wr_force = wr_en && (wr_addr == AW'(REG_FORCE));
    assign flag_clr = wr_flag ? wr_data[NCH-1:0] : '0;
    assign ch_force = wr_force ? wr_data[NCH-1:0] : '0;
    assign mt_force = wr_force ? wr_data[FORCE_MT_LSB +: NBASE] : '0;
    assign mod_off  = !menable || (wr_ctrl && !wr_data[0]);

    // Control registers and load values written from the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            menable <= 1'b0;
            chen    <= '0;
            sel     <= '0;
            irqen   <= '0;
            mload   <= '0;
            cload   <= '0;
        end else if (wr_en) begin
            if (wr_ctrl) menable <= wr_data[0];
            if (wr_addr == AW'(REG_CHEN))  chen  <= wr_data[NCH-1:0];
            if (wr_addr == AW'(REG_SEL))   sel   <= wr_data[NCH-1:0];
            if (wr_addr == AW'(REG_IRQEN)) irqen <= wr_data[NCH-1:0];
            for (int b = 0; b < NBASE; b++) begin
                if (wr_addr == AW'(REG_MLOAD + b)) mload[b] <= wr_data[MW-1:0];
            end
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(CLOAD_BASE + i)) cload[i] <= wr_data;
            end
        end
    end

    // Sticky flags: set by time-out over clear, wiped when the module is off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (mod_off) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~flag_clr) | timeout;
        end
    end

    // Read selection over the whole map
    always_comb begin
        rd_mux = '0;
        case (int'(rd_addr))
            REG_CTRL:  rd_mux = CW'(menable);
            REG_CHEN:  rd_mux = CW'(chen);
            REG_SEL:   rd_mux = CW'(sel);
            REG_FLAG:  rd_mux = CW'(flags);
            REG_IRQEN: rd_mux = CW'(irqen);
            default:   rd_mux = '0;
        endcase
        for (int b = 0; b < NBASE; b++) begin
            if (int'(rd_addr) == REG_MLOAD + b) rd_mux = CW'(mload[b]);
        end
        for (int i = 0; i < NCH; i++) begin
            if (int'(rd_addr) == CLOAD_BASE + i) rd_mux = cload[i];
            if (int'(rd_addr) == CNT_BASE + i)   rd_mux = cnts[i];
        end
    end

    // Registered read data, captured whole on the request edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/dual_base_period_timer.sv
// Top of the dual-base periodic timer.
// Two micro base prescalers feed NCH channel counters through per-channel
// select bits. A base runs only while at least one enabled channel selects
// it. Time-outs drive sticky flags, gated irq lines and one-cycle triggers.
module dual_base_period_timer
    import dbpt_pkg::*;
#(
    parameter  int NCH = 4,
    parameter  int MW  = 8,
    parameter  int CW  = 16,
    localparam int AW  = $clog2(regmap_size(NCH))
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [CW-1:0]  wr_data_i,
    input  logic           rd_en_i,
    input  logic [AW-1:0]  rd_addr_i,
    output logic [CW-1:0]  rd_data_o,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] trig_o
);
    logic                     menable;
    logic [NCH-1:0]           chen, sel, ch_force, flags, irqen;
    logic [NCH-1:0]           ch_en, ch_tick, timeout;
    logic [NBASE-1:0]         mt_force, base_active, mtick;
    logic [NBASE-1:0][MW-1:0] mload;
    logic [NCH-1:0][CW-1:0]   cload, cnts;
    logic [NCH-1:0]           trig_q;

    dbpt_regs #(.NCH(NCH), .MW(MW), .CW(CW), .AW(AW)) u_regs (
        .clk      (clk_i),
        .rst_n    (rst_ni),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rd_en    (rd_en_i),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o),
        .timeout  (timeout),
        .cnts     (cnts),
        .menable  (menable),
        .chen     (chen),
        .sel      (sel),
        .ch_force (ch_force),
        .mt_force (mt_force),
        .mload    (mload),
        .cload    (cload),
        .flags    (flags),
        .irqen    (irqen)
    );

    assign ch_en = {NCH{menable}} & chen;
    assign irq_o = flags & irqen;
    assign trig_o = trig_q;

    // A base is active while any enabled channel selects it
    always_comb begin
        base_active = '0;
        for (int b = 0; b < NBASE; b++) begin
            for (int i = 0; i < NCH; i++) begin
                if (ch_en[i] && (int'(sel[i]) == b)) base_active[b] = 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NBASE; b++) begin : g_base
        dbpt_microbase #(.MW(MW)) u_base (
            .clk      (clk_i),
            .rst_n    (rst_ni),
            .active   (base_active[b]),
            .force_ld (mt_force[b]),
            .load_val (mload[b]),
            .tick     (mtick[b])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign ch_tick[i] = mtick[sel[i]];
        dbpt_channel #(.CW(CW)) u_chan (
            .clk      (clk_i),
            .rst_n    (rst_ni),
            .en       (ch_en[i]),
            .tick     (ch_tick[i]),
            .force_ld (ch_force[i]),
            .load_val (cload[i]),
            .count    (cnts[i]),
            .timeout  (timeout[i])
        );
    end

    // Trigger pulse register: one cycle per time-out
    always_ff @(posedge clk_i) begin
        if (!rst_ni) trig_q <= '0;
        else         trig_q <= timeout;
    end
endmodule

// File: rtl/dbpt_chk.sv
// Checker for the dual-base periodic timer, bound into the top.
// Relates the flags, irq lines, triggers and channel counts over time.
module dbpt_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   menable,
    input logic [NCH-1:0]         flags,
    input logic [NCH-1:0]         irqen,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         trig,
    input logic [NCH-1:0]         ch_en,
    input logic [NCH-1:0]         ch_force,
    input logic [NCH-1:0]         ch_tick,
    input logic [NCH-1:0]         timeout,
    input logic [NCH-1:0][CW-1:0] cnts
);
    // R12
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !menable |-> (flags == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R9
        trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trig[i] && menable) |-> flags[i]);
        // R10
        irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (flags[i] && irqen[i]));
        // R11
        trig_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            timeout[i] |=> trig[i]);
        // R1
        timeout_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            timeout[i] |-> ch_tick[i]);
        // R4
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[i] && !ch_force[i]) |=> $stable(cnts[i]));
        // R2
        step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && $past(ch_en[i]) && ch_tick[i] && !ch_force[i] && (cnts[i] != '0))
            |=> (cnts[i] == $past(cnts[i]) - CW'(1)));
    end
endmodule

bind dual_base_period_timer dbpt_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .menable  (menable),
    .flags    (flags),
    .irqen    (irqen),
    .irq      (irq_o),
    .trig     (trig_o),
    .ch_en    (ch_en),
    .ch_force (ch_force),
    .ch_tick  (ch_tick),
    .timeout  (timeout),
    .cnts     (cnts)
);

// File: tb/dual_base_period_timer_bench.sv
// Self-checking bench: sweeps the stage loads and measures trigger periods.
// Also times the forced reloads and provokes a flag clear on a time-out edge.
module dual_base_period_timer_bench;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam int A_CTRL = 0, A_CHEN = 1, A_SEL = 2, A_FORCE = 3, A_FLAG = 4;
    localparam int A_IRQEN = 5, A_ML0 = 6, A_ML1 = 7, A_CL0 = 8, A_CNT0 = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0, rd_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [CW-1:0]  rd_data;
    logic [NCH-1:0] irq, trig;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_base_period_timer u_dual_base_period_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .trig_o    (trig)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_en = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rd_data);
    endtask

    task automatic wait_trig(input int ch);
        int n = 0;
        while (!trig[ch] && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int ch, output int p);
        wait_trig(ch);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!trig[ch] && p < 5000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, v2, p, n, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 trig after reset", int'(trig), 0);
        chk("R12 irq after reset", int'(irq), 0);
        rd(A_CNT0, v);  chk("R12 count after reset", v, 0);
        rd(A_FLAG, v);  chk("R12 flags after reset", v, 0);

        wr(A_CTRL, 1);
        // R1 R2 sweep of both stages on channel 0, base 0
        for (int ml = 0; ml < 4; ml++) begin
            for (int cl = 0; cl < 4; cl++) begin
                wr(A_CHEN, 0); wr(A_ML0, ml); wr(A_CL0, cl); wr(A_CHEN, 1);
                measure(0, p);
                chk((cl == 0) ? "R1 base tick period" : "R2 channel period", p, (ml + 1) * (cl + 1));
            end
        end

        // R3 channel 3 on base 1
        wr(A_CHEN, 0); wr(A_SEL, 8);
        for (int k = 0; k < 4; k++) begin
            int ml = (k < 2) ? 5 : 7;
            int cl = (k % 2) * 2;
            wr(A_CHEN, 0); wr(A_ML1, ml); wr(A_CL0 + 3, cl); wr(A_CHEN, 8);
            measure(3, p);
            chk("R3 base1 period", p, (ml + 1) * (cl + 1));
        end

        // R3 two channels on different bases, then re-routed
        wr(A_CHEN, 0);
        wr(A_ML0, 1); wr(A_CL0, 2); wr(A_ML1, 4); wr(A_CL0 + 1, 1);
        wr(A_SEL, 2); wr(A_CHEN, 3);
        measure(0, p); chk("R3 ch0 on base0", p, 6);
        measure(1, p); chk("R3 ch1 on base1", p, 10);
        wr(A_SEL, 0);
        measure(1, p); measure(1, p);
        chk("R3 ch1 re-routed to base0", p, 4);

        // R11 pulse is one cycle wide, irq enable still clear
        wait_trig(1);
        chk("R11 trig high", int'(trig[1]), 1);
        @(negedge clk);
        chk("R11 trig one cycle", int'(trig[1]), 0);

        // R4 channel enables off: counts hold, no triggers
        wr(A_CHEN, 0);
        rd(A_CNT0 + 1, v);
        seen = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (trig != '0) seen++;
        end
        rd(A_CNT0 + 1, v2);
        chk("R4 count held while disabled", v2, v);
        chk("R4 no trigger while disabled", seen, 0);

        // R5 R8 enable reloads the count, read is one cycle behind
        wr(A_ML0, 0); wr(A_CL0, 50); wr(A_CHEN, 1);
        rd(A_CNT0, v);
        rd(A_CNT0, v);  chk("R5 load on enable", v, 50);
        rd(A_CNT0, v);  chk("R8 read of next count", v, 49);

        // R6 channel force reload
        wr(A_CL0, 100); wr(A_FORCE, 1);
        rd(A_CNT0, v);  chk("R6 force reload value", v, 100);
        rd(A_CNT0, v);  chk("R6 counting after force", v, 99);

        // R7 base force reload restarts the tick phase
        wr(A_ML0, 9); wr(A_CL0, 0); wr(A_FORCE, 'h101);
        n = 0;
        do begin @(negedge clk); n++; end while (!trig[0] && n < 100);
        chk("R7 first tick after base force", n, 10);
        repeat (4) @(negedge clk);
        wr(A_FORCE, 'h100);
        n = 0;
        do begin @(negedge clk); n++; end while (!trig[0] && n < 100);
        chk("R7 mid-phase base force", n, 10);

        // R9 flag clear, away from and on a time-out edge
        wr(A_ML0, 3); wr(A_CL0, 1); wr(A_FORCE, 'h101);
        measure(0, p); chk("R2 period 8", p, 8);
        wr(A_FLAG, 1);
        rd(A_FLAG, v);  chk("R9 clear away from time-out", v & 1, 0);
        wait_trig(0);
        repeat (7) @(negedge clk);
        wr(A_FLAG, 1);
        chk("R9 time-out on the clear edge", int'(trig[0]), 1);
        rd(A_FLAG, v);  chk("R9 set wins over clear", v & 1, 1);

        // R10 irq gating
        chk("R10 irq off without enable", int'(irq[0]), 0);
        wr(A_IRQEN, 1);
        chk("R10 irq with flag and enable", int'(irq[0]), 1);

        // R12 module disable clears flags and stops counters
        wr(A_CTRL, 0);
        chk("R12 irq after disable", int'(irq), 0);
        rd(A_FLAG, v);  chk("R12 flags after disable", v, 0);
        rd(A_CNT0, v);
        seen = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (trig != '0) seen++;
        end
        rd(A_CNT0, v2);
        chk("R12 counter stopped", v2, v);
        chk("R12 no trigger when off", seen, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule